// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block keeps a wide free-running tally of clock cycles for performance measurement. A small set of control fields, loaded together through a single write strobe, selects whether it runs, whether it advances on every clock or only once per 64 clocks, and which carry out of the tally counts as an overflow. A further field makes the counter pause whenever the surrounding logic reports that counting is prohibited or frozen.

A one-shot clear field zeroes the tally and the prescaler without touching the overflow flag. The overflow flag is sticky and is dropped only by a separate write-1-to-clear input. An export permission output tells a downstream event bus whether it may carry events, taking the prohibit indication into account.

Top module: `cyc_tally`

## Requirements
- R1: After reset the count, the overflow flag, the export permission and every stored control field are zero.
- R2: When running with the divider field at 0, the count rises by one on every clock edge.
- R3: With the divider field at 1 and the long field at 0, the count rises by one once every 64 running clock edges; a 6-bit prescaler reaches 63 and the next running edge carries into the count.
- R4: With the long field at 1 the divider field has no effect and the count rises on every running edge.
- R5: With the long field at 0, an increment that wraps the low SHORT_W bits sets the overflow flag in the same edge, and the carry still propagates into the upper bits.
- R6: With the long field at 1, only an increment that wraps the whole count sets the overflow flag; a wrap of the low SHORT_W bits does not.
- R7: A control write with the clear field at 1 makes the count zero at that edge and restarts the prescaler, leaving the overflow flag as it was.
- R8: The control read-back ctrlView has bit 0 run, bit 1 clear, bit 2 divider, bit 3 long, bit 4 gate, bit 5 export; bit 1 always reads 0.
- R9: With the gate field at 1, the count and the prescaler hold while prohibit or freeze is high; with the gate field at 0 those inputs do not affect counting.
- R10: With the run field at 0 the count does not change.
- R11: Once set, the overflow flag stays high until ovfClear is pulsed; an overflow in the same edge as ovfClear keeps it set.
- R12: exportEn is high exactly when the export field is 1 and prohibit is low, whatever the overflow flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Loads all control fields at this edge |
| cfgEnable | input | 1 | Run field |
| cfgDivide | input | 1 | Divide-by-64 field |
| cfgLong | input | 1 | Full-width overflow field |
| cfgGateProhib | input | 1 | Pause while prohibited or frozen |
| cfgExport | input | 1 | Event export permission field |
| cfgClearCnt | input | 1 | Write-only clear of count and prescaler |
| prohibit | input | 1 | Counting is prohibited in the current region |
| freeze | input | 1 | Counting is frozen |
| ovfClear | input | 1 | Write-1-to-clear of the overflow flag |
| count | output | CNT_W (64) | Cycle count |
| ovfFlag | output | 1 | Sticky overflow flag |
| exportEn | output | 1 | Events may be exported |
| ctrlView | output | 6 | Read-back of the stored control fields |

## Verification
The properties assume that ctrlView faithfully mirrors the fields used in the cycle it is sampled, so every counting rule is expressed as a relation between that read-back, the prohibit and freeze inputs and the next count. They also take the prohibit and freeze inputs to be synchronous levels that change only between edges; the stimulus drives every input on the falling edge and holds it across the next rising edge. The bench instantiates narrow widths so both overflow positions are reached within a few thousand cycles.

// File: rtl/cyc_tally_pkg.sv
package cyc_tally_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic tick;      // advance the count this edge
    logic zero;      // clear the count this edge
    logic longMode;  // overflow is taken from the full width
  } cntStrobe_t;
endpackage

// File: rtl/cyc_tally_ctrl.sv
module cyc_tally_ctrl
  import cyc_tally_pkg::*;
#(
  parameter int PRESC_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgEnable,
  input  logic       cfgDivide,
  input  logic       cfgLong,
  input  logic       cfgGateProhib,
  input  logic       cfgExport,
  input  logic       cfgClearCnt,
  input  logic       prohibit,
  input  logic       freeze,
  output cntStrobe_t strobe,
  output logic [5:0] ctrlView,
  output logic       exportEn
);
  localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

  logic enR, divR, longR, gateR, expR;
  logic [PRESC_W-1:0] presc;
  logic active, divEff, zeroNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR   <= 1'b0;
      divR  <= 1'b0;
      longR <= 1'b0;
      gateR <= 1'b0;
      expR  <= 1'b0;
    end else if (cfgWrEn) begin
      enR   <= cfgEnable;
      divR  <= cfgDivide;
      longR <= cfgLong;
      gateR <= cfgGateProhib;
      expR  <= cfgExport;
    end
  end

  always_comb begin
    active  = enR && !(gateR && (prohibit || freeze));
    divEff  = divR && !longR;
    zeroNow = cfgWrEn && cfgClearCnt;
  end

  // Prescaler: holds while not active, restarts on a clear write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 presc <= '0;
    else if (zeroNow)          presc <= '0;
    else if (active && divEff) presc <= presc + 1'b1;
  end

  always_comb begin
    strobe.zero     = zeroNow;
    strobe.tick     = !zeroNow && active && (!divEff || presc == PRESC_LAST);
    strobe.longMode = longR;
    ctrlView        = {expR, gateR, longR, divR, 1'b0, enR};
    exportEn        = expR && !prohibit;
  end
endmodule

// File: rtl/cyc_tally_dp.sv
module cyc_tally_dp
  import cyc_tally_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SHORT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic             ovfClear,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  localparam int LOW_W = (SHORT_W < CNT_W) ? SHORT_W : CNT_W;

  logic lowFull, allFull, wrapNow;

  generate
    if (LOW_W == CNT_W) begin : gSameWidth
      assign lowFull = &count;
    end else begin : gSplitWidth
      assign lowFull = &count[LOW_W-1:0];
    end
  endgenerate

  always_comb begin
    allFull = &count;
    wrapNow = strobe.tick && (strobe.longMode ? allFull : lowFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.zero) count <= '0;
    else if (strobe.tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ovfFlag <= 1'b0;
    else if (wrapNow)  ovfFlag <= 1'b1;
    else if (ovfClear) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/cyc_tally.sv
module cyc_tally
  import cyc_tally_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SHORT_W = 32,
  parameter int PRESC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgEnable,
  input  logic             cfgDivide,
  input  logic             cfgLong,
  input  logic             cfgGateProhib,
  input  logic             cfgExport,
  input  logic             cfgClearCnt,
  input  logic             prohibit,
  input  logic             freeze,
  input  logic             ovfClear,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             exportEn,
  output logic [5:0]       ctrlView
);
  cntStrobe_t strobe;

  cyc_tally_ctrl #(.PRESC_W(PRESC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgEnable(cfgEnable),
    .cfgDivide(cfgDivide), .cfgLong(cfgLong), .cfgGateProhib(cfgGateProhib),
    .cfgExport(cfgExport), .cfgClearCnt(cfgClearCnt), .prohibit(prohibit),
    .freeze(freeze), .strobe(strobe), .ctrlView(ctrlView), .exportEn(exportEn)
  );

  cyc_tally_dp #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ovfClear(ovfClear),
    .count(count), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/cyc_tally_chk.sv
module cyc_tally_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             cfgClearCnt,
  input logic             prohibit,
  input logic             freeze,
  input logic             ovfClear,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             exportEn,
  input logic [5:0]       ctrlView
);
  logic clearWr, gated, everyEdge;
  assign clearWr   = cfgWrEn && cfgClearCnt;
  assign gated     = ctrlView[4] && (prohibit || freeze);
  assign everyEdge = !ctrlView[2] || ctrlView[3];

  // R2
  step_every_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[0] && everyEdge && !gated && !clearWr)
      |=> count == CNT_W'($past(count) + 1'b1));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearWr |=> count == '0);

  // R7
  clear_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !ovfClear) |=> ovfFlag == $past(ovfFlag) || $rose(ovfFlag) == 1'b0 && ovfFlag == $past(ovfFlag));

  // R8
  always_comb begin
    clear_reads_zero_chk: assert (!rstN || ctrlView[1] == 1'b0);
  end

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gated && !clearWr) |=> $stable(count));

  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlView[0] && !clearWr) |=> $stable(count));

  // R11
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag);

  // R12
  export_prohibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    exportEn |-> (!prohibit && ctrlView[5]));
endmodule

bind cyc_tally cyc_tally_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgClearCnt(cfgClearCnt),
  .prohibit(prohibit), .freeze(freeze), .ovfClear(ovfClear), .count(count),
  .ovfFlag(ovfFlag), .exportEn(exportEn), .ctrlView(ctrlView)
);

// File: tb/sim_cyc_tally.sv
module sim_cyc_tally;
  localparam int CW = 12;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgEnable = 0, cfgDivide = 0, cfgLong = 0;
  logic cfgGateProhib = 0, cfgExport = 0, cfgClearCnt = 0;
  logic prohibit = 0, freeze = 0, ovfClear = 0;
  logic [CW-1:0] count;
  logic ovfFlag, exportEn;
  logic [5:0] ctrlView;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cyc_tally #(.CNT_W(CW), .SHORT_W(SW), .PRESC_W(6)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgEnable(cfgEnable),
    .cfgDivide(cfgDivide), .cfgLong(cfgLong), .cfgGateProhib(cfgGateProhib),
    .cfgExport(cfgExport), .cfgClearCnt(cfgClearCnt), .prohibit(prohibit),
    .freeze(freeze), .ovfClear(ovfClear), .count(count), .ovfFlag(ovfFlag),
    .exportEn(exportEn), .ctrlView(ctrlView)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic en, input logic dv, input logic lg,
                          input logic gt, input logic ex, input logic cl);
    cfgEnable = en; cfgDivide = dv; cfgLong = lg;
    cfgGateProhib = gt; cfgExport = ex; cfgClearCnt = cl;
    cfgWrEn = 1'b1;
    step(1);
    cfgWrEn = 1'b0; cfgClearCnt = 1'b0;
  endtask

  task automatic testReset;
    chk("R1 count", 32'(count), 0);
    chk("R1 flag", 32'(ovfFlag), 0);
    chk("R1 export", 32'(exportEn), 0);
    chk("R1 ctrlView", 32'(ctrlView), 0);
  endtask

  task automatic testPlain;
    writeCfg(1, 0, 0, 0, 0, 1);
    chk("R7 cleared", 32'(count), 0);
    step(10);
    chk("R2 every edge", 32'(count), 10);
  endtask

  task automatic testStopped;
    logic [CW-1:0] held;
    writeCfg(0, 0, 0, 0, 0, 0);
    held = count;
    step(5);
    chk("R10 stopped", 32'(count), 32'(held));
  endtask

  task automatic testDivide;
    writeCfg(1, 1, 0, 0, 0, 1);
    step(63);
    chk("R3 before 64", 32'(count), 0);
    step(1);
    chk("R3 at 64", 32'(count), 1);
    step(64);
    chk("R3 at 128", 32'(count), 2);
  endtask

  task automatic testGate;
    writeCfg(1, 1, 0, 1, 0, 1);
    step(30);
    freeze = 1'b1;
    step(20);
    chk("R9 frozen", 32'(count), 0);
    freeze = 1'b0;
    step(33);
    chk("R9 prescaler held", 32'(count), 0);
    step(1);
    chk("R9 resumed", 32'(count), 1);
    prohibit = 1'b1;
    writeCfg(1, 0, 0, 0, 0, 1);
    step(5);
    chk("R9 gate off", 32'(count), 5);
    prohibit = 1'b0;
  endtask

  task automatic testLongOverride;
    writeCfg(1, 1, 1, 0, 0, 1);
    step(10);
    chk("R4 divider ignored", 32'(count), 10);
  endtask

  task automatic testShortOvf;
    writeCfg(1, 0, 0, 0, 0, 1);
    step(63);
    chk("R5 no flag yet", 32'(ovfFlag), 0);
    step(1);
    chk("R5 flag", 32'(ovfFlag), 1);
    chk("R5 carry", 32'(count), 64);
    step(3);
    chk("R11 sticky", 32'(ovfFlag), 1);
    ovfClear = 1'b1;
    step(1);
    ovfClear = 1'b0;
    chk("R11 cleared", 32'(ovfFlag), 0);
  endtask

  task automatic testLongOvf;
    writeCfg(1, 0, 1, 0, 0, 1);
    step(64);
    chk("R6 low wrap ignored", 32'(ovfFlag), 0);
    step(4095 - 64);
    chk("R6 all ones", 32'(count), 4095);
    chk("R6 no flag", 32'(ovfFlag), 0);
    step(1);
    chk("R6 wrapped", 32'(count), 0);
    chk("R6 flag", 32'(ovfFlag), 1);
  endtask

  task automatic testClearKeepsFlag;
    step(7);
    writeCfg(1, 0, 1, 0, 0, 1);
    chk("R7 count zero", 32'(count), 0);
    chk("R7 flag kept", 32'(ovfFlag), 1);
    chk("R8 read-back", 32'(ctrlView), 32'h9);
  endtask

  task automatic testExport;
    writeCfg(0, 0, 0, 0, 1, 0);
    chk("R8 export bit", 32'(ctrlView[5]), 1);
    chk("R12 allowed", 32'(exportEn), 1);
    prohibit = 1'b1;
    #1;
    chk("R12 prohibited", 32'(exportEn), 0);
    prohibit = 1'b0;
    #1;
    chk("R12 flag independent", 32'(exportEn), 1);
  endtask

  initial begin
    step(3);
    testReset();
    rstN = 1'b1;
    step(2);
    testReset();
    testPlain();
    testStopped();
    testDivide();
    testGate();
    testLongOverride();
    testShortOvf();
    testLongOvf();
    testClearKeepsFlag();
    testExport();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule